// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a single-clock synchronous memory whose data bus can carry a read or a write on every cycle, in any mix, with no idle cycles when the direction changes. All inputs are registered on the rising edge. Read data is flow-through: it comes straight out of storage in the cycle after the edge that accepted the read. Write data lags its address by one edge. The pending address and lane enables sit in a short pipeline, and reads of a word whose new data has not reached storage yet are served by forwarding.

Each word is 18 bits, split into two 9-bit lanes that can be written independently. Depth is set by an address-width parameter. A load can be followed by advance cycles that step through the other three words of an aligned group of four, in either linear or interleaved order, repeating the loaded command type. A clock-enable input freezes the whole block for an edge. A sleep input refuses new commands but keeps memory contents. The block serves as a memory model or as an on-chip buffer.

Top module: `nowait_sram`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rdata` is 0 until a read is accepted.
- R2: A load command (`adv`=0) is accepted only when `sel_p`=1, `sel_n1`=0 and `sel_n2`=0. Any other combination gives an idle cycle (`rd_valid`=0) and ends the current burst, so a later advance does nothing.
- R3: A read accepted at an edge (`we_cmd`=0) sets `rd_valid`=1, and `rdata` shows the stored word during the following cycle. In every cycle without an accepted read, `rd_valid`=0 and `rdata`=0.
- R4: For a write accepted at an edge (`we_cmd`=1), the address and lane enables are taken at that edge. The data is taken from `wdata` at the next enabled edge.
- R5: Reads and writes may alternate on consecutive cycles. A read of a word whose write data has been taken but not yet stored returns the new lanes merged over the old word.
- R6: `lane_we[k]` enables `wdata[9k+8:9k]`, with lane 0 in bits 8:0 and lane 1 in bits 17:9. Lanes whose enable is 0 keep their old contents, and a write with both enables at 0 changes nothing.
- R7: While `clk_en`=0, edges are ignored. No command is taken, no write data is taken, the burst position holds, and `rd_valid` and `rdata` hold their values.
- R8: With `adv`=1 after an accepted load, each beat repeats the loaded command type. The upper address bits stay fixed, and the low two bits in linear mode (`burst_ilv`=0 at load) are (start + k) mod 4 for beat k. Lane enables are taken fresh on each beat.
- R9: If `burst_ilv`=1 at the load, the low two bits on beat k are start XOR k. The mode stays fixed for the whole burst, even if `burst_ilv` changes.
- R10: While `sleep`=1, neither loads nor advances are accepted (`rd_valid`=0) and the burst position holds. Stored contents are kept, and a write accepted before sleep still takes its data at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | 1 = act on this edge, 0 = ignore it |
| sel_p | input | 1 | Chip select, active high |
| sel_n1 | input | 1 | Chip select, active low |
| sel_n2 | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = next burst beat, 0 = load new command |
| we_cmd | input | 1 | Command type on load: 1 write, 0 read |
| lane_we | input | 2 | Per-lane write enables |
| burst_ilv | input | 1 | Burst order on load: 1 interleaved, 0 linear |
| sleep | input | 1 | Refuse commands, keep contents |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data, one edge after the write command |
| rd_valid | output | 1 | A read is being served this cycle |
| rdata | output | 18 | Flow-through read data |

## Verification
A wrong burst counter or a wrong mode register shows up in the first advance beat after a load: `rdata` carries the word of the wrong address in that same cycle. A lost or stale write-pipeline entry shows in the very next cycle when a read of that address follows, or one edge later once the entry has been stored. A clock-enable or sleep gate that leaks lets `rd_valid` or `rdata` move during the frozen cycle itself. A write that lands in the wrong lane only becomes visible when that word is read back.

// File: rtl/nowait_pkg.sv
package nowait_pkg;

  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;

  // Low two address bits of burst beat 'step' from a start position.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ step;
    else     r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/nowait_cmd.sv
module nowait_cmd
  import nowait_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              sel_p,
  input  logic              sel_n1,
  input  logic              sel_n2,
  input  logic              adv,
  input  logic              we_cmd,
  input  logic              burst_ilv,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  output logic              s1_valid,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_lanes
);

  localparam int HI_W = ADDR_W - 2;

  logic            sel_ok;
  logic            load_ev;
  logic            adv_ev;
  logic            desel_ev;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_nx;
  logic [1:0]      base_q;
  logic [HI_W-1:0] hi_q;
  logic            ilv_q;
  logic            live_q;

  assign sel_ok   = sel_p & ~sel_n1 & ~sel_n2;
  assign load_ev  = clk_en & ~sleep & ~adv & sel_ok;
  assign desel_ev = clk_en & ~sleep & ~adv & ~sel_ok;
  assign adv_ev   = clk_en & ~sleep & adv & live_q;
  assign cnt_nx   = cnt_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_RD;
      s1_addr  <= '0;
      s1_lanes <= '0;
      cnt_q    <= 2'd0;
      base_q   <= 2'd0;
      hi_q     <= '0;
      ilv_q    <= 1'b0;
      live_q   <= 1'b0;
    end else if (clk_en) begin
      if (load_ev) begin
        s1_valid <= 1'b1;
        s1_op    <= we_cmd ? OP_WR : OP_RD;
        s1_addr  <= addr;
        s1_lanes <= lane_we;
        cnt_q    <= 2'd0;
        base_q   <= addr[1:0];
        hi_q     <= addr[ADDR_W-1:2];
        ilv_q    <= burst_ilv;
        live_q   <= 1'b1;
      end else if (adv_ev) begin
        s1_valid <= 1'b1;
        s1_addr  <= {hi_q, burst_lo(base_q, cnt_nx, ilv_q)};
        s1_lanes <= lane_we;
        cnt_q    <= cnt_nx;
      end else begin
        s1_valid <= 1'b0;
        if (desel_ev) live_q <= 1'b0;
      end
    end
  end

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    desel_ev |=> !s1_valid); // R2
  AST_SLEEP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> (!s1_valid && $stable(cnt_q))); // R10
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(s1_addr) && $stable(s1_valid) && $stable(cnt_q))); // R7
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && !ilv_q) |=> (s1_addr[1:0] == 2'($past(s1_addr[1:0]) + 2'd1))); // R8
  AST_BURST_HI: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) && $stable(s1_op))); // R8
  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && ilv_q) |=> ((s1_addr[1:0] ^ base_q) == cnt_q)); // R9

endmodule

// File: rtl/nowait_wpipe.sv
module nowait_wpipe
  import nowait_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    s1_valid,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [LANES-1:0]        s1_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic                    s2_valid,
  output logic [ADDR_W-1:0]       s2_addr,
  output logic [LANES-1:0]        s2_lanes,
  output logic [LANES*LANE_W-1:0] s2_data
);

  logic wr_due;
  assign wr_due = s1_valid && (s1_op == OP_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
      s2_data  <= '0;
    end else if (clk_en) begin
      s2_valid <= wr_due;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
      s2_data  <= wdata;
    end
  end

  AST_WDATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && wr_due) |=> (s2_valid && s2_data == $past(wdata) && s2_addr == $past(s1_addr))); // R4
  AST_RD_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !wr_due) |=> !s2_valid); // R3

endmodule

// File: rtl/nowait_store.sv
module nowait_store
  import nowait_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    s1_valid,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic                    s2_valid,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_lanes,
  input  logic [LANES*LANE_W-1:0] s2_data,
  output logic                    rd_valid,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] raw_word;
  logic [DW-1:0] merged;
  logic          fwd_hit;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0]    old_w,
                                               input logic [DW-1:0]    new_w,
                                               input logic [LANES-1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++) begin
      if (en[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (clk_en && s2_valid) mem[s2_addr] <= lane_merge(mem[s2_addr], s2_data, s2_lanes);
  end

  assign raw_word = mem[s1_addr];
  assign fwd_hit  = s2_valid && (s2_addr == s1_addr);
  assign merged   = fwd_hit ? lane_merge(raw_word, s2_data, s2_lanes) : raw_word;
  assign rd_valid = s1_valid && (s1_op == OP_RD);
  assign rdata    = rd_valid ? merged : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    AST_FWD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && fwd_hit && s2_lanes[g]) |->
        rdata[g*LANE_W +: LANE_W] == s2_data[g*LANE_W +: LANE_W]); // R5
  end

endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
  import nowait_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sel_p,
  input  logic                    sel_n1,
  input  logic                    sel_n2,
  input  logic                    adv,
  input  logic                    we_cmd,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    burst_ilv,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic                    rd_valid,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DW = LANES * LANE_W;

  logic              s1_valid;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic              s2_valid;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic [DW-1:0]     s2_data;

  nowait_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
    .sel_p(sel_p), .sel_n1(sel_n1), .sel_n2(sel_n2), .adv(adv),
    .we_cmd(we_cmd), .burst_ilv(burst_ilv), .lane_we(lane_we), .addr(addr),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
  );

  nowait_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes),
    .wdata(wdata),
    .s2_valid(s2_valid), .s2_addr(s2_addr), .s2_lanes(s2_lanes), .s2_data(s2_data)
  );

  nowait_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_valid(s2_valid), .s2_addr(s2_addr), .s2_lanes(s2_lanes), .s2_data(s2_data),
    .rd_valid(rd_valid), .rdata(rdata)
  );

  AST_OUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(rd_valid) && $stable(rdata))); // R7
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> (!rd_valid && rdata == '0)); // R10

endmodule

// File: tb/tb_nowait_sram.sv
`timescale 1ns/1ps
module tb_nowait_sram;

  localparam logic [2:0] GOOD = 3'b100; // {sel_p, sel_n1, sel_n2}

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        sel_p = 1'b0, sel_n1 = 1'b0, sel_n2 = 1'b0;
  logic        adv = 1'b0, we_cmd = 1'b0, burst_ilv = 1'b0, sleep = 1'b0;
  logic [1:0]  lane_we = 2'b00;
  logic [9:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic        rd_valid;
  logic [17:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [17:0] DA = 18'h2A5C3, DB = 18'h1B0F1, DC = 18'h3C0DE;
  localparam logic [17:0] D0 = 18'h00F01, D1 = 18'h11E02, D2 = 18'h22D03, D3 = 18'h33C04;

  always #2 clk = ~clk;

  nowait_sram dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_p(sel_p), .sel_n1(sel_n1),
    .sel_n2(sel_n2), .adv(adv), .we_cmd(we_cmd), .lane_we(lane_we),
    .burst_ilv(burst_ilv), .sleep(sleep), .addr(addr), .wdata(wdata),
    .rd_valid(rd_valid), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] sv, input logic a, input logic w,
                      input logic [1:0] ln, input logic [9:0] ad, input logic [17:0] wd);
    {sel_p, sel_n1, sel_n2} = sv;
    adv = a; we_cmd = w; lane_we = ln; addr = ad; wdata = wd;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [9:0] ad, input logic [17:0] wd);
    step(GOOD, 1'b0, 1'b0, 2'b00, ad, wd);
  endtask
  task automatic wr(input logic [9:0] ad, input logic [1:0] ln, input logic [17:0] wd);
    step(GOOD, 1'b0, 1'b1, ln, ad, wd);
  endtask
  task automatic av(input logic [1:0] ln, input logic [17:0] wd);
    step(GOOD, 1'b1, 1'b0, ln, 10'h000, wd);
  endtask
  task automatic nop(input logic [17:0] wd);
    step(3'b000, 1'b0, 1'b0, 2'b00, 10'h000, wd);
  endtask

  task automatic t_reset;
    chk("R1 rd_valid in reset", {17'd0, rd_valid}, 18'd0);
    rst_n = 1'b1;
    nop(18'd0);
    chk("R1 rd_valid after reset", {17'd0, rd_valid}, 18'd0);
    chk("R1 rdata after reset", rdata, 18'd0);
  endtask

  task automatic t_alternate;
    wr(10'h010, 2'b11, 18'd0);
    chk("R3 no read on write cycle", {17'd0, rd_valid}, 18'd0);
    rd(10'h010, DA);
    chk("R5 forwarded read after write", rdata, DA);
    chk("R3 rd_valid on read", {17'd0, rd_valid}, 18'd1);
    rd(10'h010, 18'd0);
    chk("R3 read from storage", rdata, DA);
    wr(10'h011, 2'b11, 18'd0);
    rd(10'h010, DB);
    chk("R5 read between writes", rdata, DA);
    wr(10'h012, 2'b11, 18'd0);
    rd(10'h011, DC);
    chk("R4 data taken one edge late", rdata, DB);
    rd(10'h012, 18'd0);
    chk("R4 second write data", rdata, DC);
  endtask

  task automatic t_lanes;
    logic [17:0] q, r, e;
    q = 18'h0ABCD; r = 18'h12345;
    wr(10'h020, 2'b11, 18'd0);
    wr(10'h020, 2'b01, 18'h3FFFF);
    rd(10'h020, q);
    e = {9'h1FF, q[8:0]};
    chk("R6 lane0 only merged", rdata, e);
    wr(10'h020, 2'b10, 18'd0);
    rd(10'h020, r);
    e = {r[17:9], q[8:0]};
    chk("R6 lane1 only merged", rdata, e);
    wr(10'h020, 2'b00, 18'd0);
    rd(10'h020, 18'h3FFFF);
    chk("R6 no lanes enabled", rdata, e);
    rd(10'h020, 18'd0);
    chk("R6 stored after no-lane write", rdata, e);
  endtask

  task automatic t_desel;
    step(3'b000, 1'b0, 1'b0, 2'b00, 10'h010, 18'd0);
    chk("R2 sel_p low", {17'd0, rd_valid}, 18'd0);
    step(3'b110, 1'b0, 1'b0, 2'b00, 10'h010, 18'd0);
    chk("R2 sel_n1 high", {17'd0, rd_valid}, 18'd0);
    step(3'b101, 1'b0, 1'b0, 2'b00, 10'h010, 18'd0);
    chk("R2 sel_n2 high", {17'd0, rd_valid}, 18'd0);
    av(2'b00, 18'd0);
    chk("R2 advance after deselect", {17'd0, rd_valid}, 18'd0);
    chk("R3 idle rdata", rdata, 18'd0);
  endtask

  task automatic t_clken;
    rd(10'h010, 18'd0);
    chk("R7 setup read", rdata, DA);
    clk_en = 1'b0;
    for (int i = 0; i < 2; i++) begin
      wr(10'h011, 2'b11, 18'h3FFFF);
      chk("R7 rd_valid held", {17'd0, rd_valid}, 18'd1);
      chk("R7 rdata held", rdata, DA);
    end
    clk_en = 1'b1;
    wr(10'h030, 2'b11, 18'd0);
    clk_en = 1'b0;
    rd(10'h030, 18'h11111);
    rd(10'h030, 18'h22222);
    clk_en = 1'b1;
    rd(10'h030, DC);
    chk("R7 write data at next enabled edge", rdata, DC);
    rd(10'h011, 18'd0);
    chk("R7 ignored write left word", rdata, DB);
  endtask

  task automatic t_linear;
    wr(10'h041, 2'b11, 18'd0);
    av(2'b11, D0);
    av(2'b11, D1);
    av(2'b11, D2);
    nop(D3);
    rd(10'h041, 18'd0); chk("R8 write beat 0 at 0x41", rdata, D0);
    rd(10'h042, 18'd0); chk("R8 write beat 1 at 0x42", rdata, D1);
    rd(10'h043, 18'd0); chk("R8 write beat 2 at 0x43", rdata, D2);
    rd(10'h040, 18'd0); chk("R8 write beat 3 wraps to 0x40", rdata, D3);
    rd(10'h042, 18'd0); chk("R8 read load 0x42", rdata, D1);
    av(2'b00, 18'd0);   chk("R8 read beat 1", rdata, D2);
    clk_en = 1'b0;
    av(2'b00, 18'd0);   chk("R7 burst frozen", rdata, D2);
    clk_en = 1'b1;
    av(2'b00, 18'd0);   chk("R8 read beat 2 wraps", rdata, D3);
    av(2'b00, 18'd0);   chk("R8 read beat 3", rdata, D0);
  endtask

  task automatic t_interleave;
    burst_ilv = 1'b1;
    rd(10'h041, 18'd0); chk("R9 load 0x41", rdata, D0);
    burst_ilv = 1'b0;
    av(2'b00, 18'd0);   chk("R9 beat 1 is 0x40", rdata, D3);
    av(2'b00, 18'd0);   chk("R9 beat 2 is 0x43", rdata, D2);
    av(2'b00, 18'd0);   chk("R9 beat 3 is 0x42", rdata, D1);
  endtask

  task automatic t_sleep;
    rd(10'h010, 18'd0);
    sleep = 1'b1;
    rd(10'h011, 18'd0);
    chk("R10 load refused", {17'd0, rd_valid}, 18'd0);
    sleep = 1'b0;
    rd(10'h041, 18'd0);
    chk("R10 burst load", rdata, D0);
    sleep = 1'b1;
    av(2'b00, 18'd0);
    chk("R10 advance refused", {17'd0, rd_valid}, 18'd0);
    sleep = 1'b0;
    av(2'b00, 18'd0);
    chk("R10 burst resumes at 0x42", rdata, D1);
    wr(10'h050, 2'b11, 18'd0);
    sleep = 1'b1;
    rd(10'h050, DB);
    chk("R10 sleep cycle idle", rdata, 18'd0);
    sleep = 1'b0;
    rd(10'h050, 18'd0);
    chk("R10 pending write completed", rdata, DB);
    rd(10'h010, 18'd0);
    chk("R10 contents kept", rdata, DA);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_alternate();
    t_lanes();
    t_desel();
    t_clken();
    t_linear();
    t_interleave();
    t_sleep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule